// File: doc/BRIEF.md
# Streaming In-Place Radix-2 FFT Engine

This block computes a fixed-point complex FFT of N points over two valid/ready streams. A frame goes through three strictly sequential phases. First it takes in N samples, each 32 bits wide and packed as {imag[15:0], real[15:0]}. Each sample is written to the bit-reversed copy of its arrival index. Next the block runs every decimation-in-time radix-2 butterfly in place on that one buffer. Last it streams the N results out in natural frequency order. A new frame is taken in only after the previous one has fully left.

The real and imaginary halves live in separate memories, so a complex word is read or written in a single cycle. One shared butterfly datapath multiplies by a twiddle factor and then applies an arithmetic right shift. The twiddle factors are stored in a constant table that is filled at elaboration. A stage/group/branch sequencer generates the operand addresses. No start command is needed: the computation begins as soon as the N-th sample is accepted. A status counter reports how long the transform took.

Top module: `fft_stream_core`

## Requirements
- R1: `in_ready` is high only in the load phase. It stays low from the acceptance of the N-th sample until the last result of that frame has been accepted.
- R2: Output k, in natural order, equals the DFT sum over n of x[n]·e^(−j2πnk/N). Real and imaginary parts are each within 2·log2(N)² of the exact value. No per-stage scaling is applied. Samples and results use the packing {imag[15:0], real[15:0]}.
- R3: A frame runs exactly (N/2)·log2(N) butterflies at 3 clocks each. The first `out_valid` rises 3·(N/2)·log2(N)+3 clock edges after the edge that accepts the N-th sample.
- R4: With the partner always ready, consecutive accepted samples are exactly 3 clocks apart. The same holds for consecutive accepted results.
- R5: When the first result of a frame is presented, `lat_cycles` equals 3·(N/2)·log2(N)+3.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: `done` is high for exactly one cycle, the cycle after the last result is accepted. In that same cycle `in_ready` is high again for the next frame.
- R8: An impulse of value A at input index 0 with all other samples zero gives exactly A on every output.
- R9: During and right after reset, `in_ready` is 1 and `out_valid`, `done` and `lat_cycles` are 0.
- R10: Additions wrap modulo 2^16 with no saturation. For example, N=64 equal real samples of 1000 give real part −1536 at output 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine takes a sample on this edge |
| in_data | input | 2·DW | Sample {imag, real} |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2·DW | Result {imag, real} |
| done | output | 1 | One-cycle pulse after the last result |
| lat_cycles | output | CW | Clocks from last sample in to first result valid |

## Verification
Some properties are checked on every cycle. These are: output hold under back-pressure, the single-cycle `done` pulse, the exact butterfly total at the end of each compute phase, the latency counter value at the first result, and the fact that every operand pair differs in exactly one address bit. Numerical correctness cannot be seen cycle by cycle. It shows only in whole-frame scenarios: random frames compared with a real-valued reference DFT, an exact impulse, and a DC frame whose sum wraps. The bench also measures the 3-clock I/O spacing and the compute latency at the ports.

// File: rtl/fft_pkg.sv
package fft_pkg;
   typedef enum logic [1:0] {
      PH_LOAD  = 2'd0,
      PH_CALC  = 2'd1,
      PH_DRAIN = 2'd2
   } phase_t;

   localparam int STEPS_PER_ITEM = 3;
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
   parameter int N         = 1024,
   parameter int DW        = 16,
   parameter int FAC_SHIFT = 14,
   localparam int KW       = $clog2(N) - 1
) (
   input  logic [KW-1:0]          k,
   output logic signed [DW-1:0]   w_re,
   output logic signed [DW-1:0]   w_im
);
   localparam real TWO_PI = 6.283185307179586;

   function automatic logic signed [DW-1:0] quant(input real v);
      return DW'($rtoi($floor(v * (2.0 ** FAC_SHIFT) + 0.5)));
   endfunction

   logic signed [DW-1:0] cos_tab [N/2];
   logic signed [DW-1:0] nsin_tab [N/2];

   for (genvar t = 0; t < N/2; t++) begin : g_tab
      localparam real ANG = TWO_PI * t / N;
      assign cos_tab[t]  = quant($cos(ANG));
      assign nsin_tab[t] = quant(-$sin(ANG));
   end

   assign w_re = cos_tab[k];
   assign w_im = nsin_tab[k];
endmodule

// File: rtl/fft_fly_seq.sv
module fft_fly_seq #(
   parameter int N   = 1024,
   localparam int AW = $clog2(N),
   localparam int SW = $clog2(AW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] idx_i,
   output logic [AW-1:0] idx_j,
   output logic [AW-2:0] tw_k,
   output logic          last
);
   logic [SW-1:0] stg;
   logic [AW-2:0] mid;
   logic [AW-1:0] base;
   logic [AW-1:0] half;
   logic [AW:0]   nxt_base;
   logic          mid_last;
   logic          base_wrap;

   assign half      = AW'(1) << stg;
   assign nxt_base  = {1'b0, base} + ({1'b0, half} << 1);
   assign base_wrap = (nxt_base == (AW+1)'(N));
   assign mid_last  = (({1'b0, mid}) + AW'(1)) == half;
   assign idx_i     = base + {1'b0, mid};
   assign idx_j     = idx_i + half;
   assign tw_k      = mid << (SW'(AW - 1) - stg);
   assign last      = (stg == SW'(AW - 1)) && mid_last && base_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg  <= '0;
         mid  <= '0;
         base <= '0;
      end else if (adv) begin
         if (!base_wrap) begin
            base <= nxt_base[AW-1:0];
         end else begin
            base <= '0;
            if (mid_last) begin
               mid <= '0;
               stg <= (stg == SW'(AW - 1)) ? '0 : stg + SW'(1);
            end else begin
               mid <= mid + 1'b1;
            end
         end
      end
   end

   AST_PAIR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_j > idx_i) && ($countones(idx_i ^ idx_j) == 1)); // R3
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
   parameter int DW        = 16,
   parameter int FAC_SHIFT = 14,
   localparam int PW       = 2 * DW
) (
   input  logic                 clk,
   input  logic                 cap,
   input  logic                 mul,
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic signed [DW-1:0] w_re,
   input  logic signed [DW-1:0] w_im,
   output logic signed [DW-1:0] top_re,
   output logic signed [DW-1:0] top_im,
   output logic signed [DW-1:0] bot_re,
   output logic signed [DW-1:0] bot_im
);
   logic signed [DW-1:0] ar, ai, br, bi, wr, wi, tr, ti;
   logic signed [PW-1:0] pr, pi;

   always_comb begin
      pr = PW'(wr) * PW'(br) - PW'(wi) * PW'(bi);
      pi = PW'(wr) * PW'(bi) + PW'(wi) * PW'(br);
   end

   always_ff @(posedge clk) begin
      if (cap) begin
         ar <= a_re;
         ai <= a_im;
         br <= b_re;
         bi <= b_im;
         wr <= w_re;
         wi <= w_im;
      end
      if (mul) begin
         tr <= DW'(pr >>> FAC_SHIFT);
         ti <= DW'(pi >>> FAC_SHIFT);
      end
   end

   assign top_re = ar + tr;
   assign top_im = ai + ti;
   assign bot_re = ar - tr;
   assign bot_im = ai - ti;
endmodule

// File: rtl/fft_stream_core.sv
module fft_stream_core #(
   parameter int N         = 1024,
   parameter int DW        = 16,
   parameter int FAC_SHIFT = 14,
   parameter int CW        = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [2*DW-1:0] in_data,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [2*DW-1:0] out_data,
   output logic            done,
   output logic [CW-1:0]   lat_cycles
);
   import fft_pkg::*;

   localparam int AW    = $clog2(N);
   localparam int FLIES = (N / 2) * AW;
   localparam int LAT   = STEPS_PER_ITEM * FLIES + 3;

   if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("N must be a power of two of at least 4");
   end
   if (FAC_SHIFT > DW - 2 || FAC_SHIFT < 1) begin : g_bad_shift
      $error("FAC_SHIFT must lie in 1..DW-2");
   end
   if (CW < 16) begin : g_bad_cw
      $error("CW too narrow for the latency count");
   end

   phase_t               phase;
   logic [1:0]           step;
   logic [AW-1:0]        ptr;
   logic [AW-1:0]        ptr_rev;
   logic signed [DW-1:0] hold_re, hold_im;
   logic signed [DW-1:0] mem_re [N];
   logic signed [DW-1:0] mem_im [N];
   logic signed [DW-1:0] o_re, o_im;
   logic [CW-1:0]        cnt;
   logic                 cnt_run;

   logic [AW-1:0]        idx_i, idx_j, rd_a;
   logic [AW-2:0]        tw_k;
   logic                 fly_last, adv;
   logic signed [DW-1:0] w_re, w_im;
   logic signed [DW-1:0] top_re, top_im, bot_re, bot_im;
   logic                 we_a, we_b;
   logic [AW-1:0]        wa_a;
   logic signed [DW-1:0] wd_re_a, wd_im_a;

   for (genvar b = 0; b < AW; b++) begin : g_rev
      assign ptr_rev[b] = ptr[AW-1-b];
   end

   assign in_ready   = (phase == PH_LOAD) && (step == 2'd0);
   assign out_valid  = (phase == PH_DRAIN) && (step == 2'd1);
   assign out_data   = {o_im, o_re};
   assign lat_cycles = cnt;
   assign adv        = (phase == PH_CALC) && (step == 2'd2);
   assign rd_a       = (phase == PH_CALC) ? idx_i : ptr;

   fft_fly_seq #(.N(N)) u_seq (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .idx_i(idx_i), .idx_j(idx_j), .tw_k(tw_k), .last(fly_last)
   );

   fft_twiddle_rom #(.N(N), .DW(DW), .FAC_SHIFT(FAC_SHIFT)) u_rom (
      .k(tw_k), .w_re(w_re), .w_im(w_im)
   );

   fft_bfly #(.DW(DW), .FAC_SHIFT(FAC_SHIFT)) u_bfly (
      .clk(clk),
      .cap((phase == PH_CALC) && (step == 2'd0)),
      .mul((phase == PH_CALC) && (step == 2'd1)),
      .a_re(mem_re[rd_a]), .a_im(mem_im[rd_a]),
      .b_re(mem_re[idx_j]), .b_im(mem_im[idx_j]),
      .w_re(w_re), .w_im(w_im),
      .top_re(top_re), .top_im(top_im), .bot_re(bot_re), .bot_im(bot_im)
   );

   always_comb begin
      we_a    = 1'b0;
      wa_a    = ptr_rev;
      wd_re_a = hold_re;
      wd_im_a = hold_im;
      if (phase == PH_LOAD && step == 2'd1) begin
         we_a = 1'b1;
      end else if (adv) begin
         we_a    = 1'b1;
         wa_a    = idx_i;
         wd_re_a = top_re;
         wd_im_a = top_im;
      end
      we_b = adv;
   end

   always_ff @(posedge clk) begin
      if (we_a) begin
         mem_re[wa_a] <= wd_re_a;
         mem_im[wa_a] <= wd_im_a;
      end
      if (we_b) begin
         mem_re[idx_j] <= bot_re;
         mem_im[idx_j] <= bot_im;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_LOAD;
         step    <= 2'd0;
         ptr     <= '0;
         hold_re <= '0;
         hold_im <= '0;
         o_re    <= '0;
         o_im    <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_LOAD: begin
               if (step == 2'd0) begin
                  if (in_valid) begin
                     hold_re <= in_data[DW-1:0];
                     hold_im <= in_data[2*DW-1:DW];
                     step    <= 2'd1;
                  end
               end else if (step == 2'd1) begin
                  step <= 2'd2;
               end else begin
                  step <= 2'd0;
                  ptr  <= ptr + 1'b1;
                  if (ptr == AW'(N - 1)) phase <= PH_CALC;
               end
            end
            PH_CALC: begin
               if (step == 2'd2) begin
                  step <= 2'd0;
                  if (fly_last) phase <= PH_DRAIN;
               end else begin
                  step <= step + 2'd1;
               end
            end
            PH_DRAIN: begin
               if (step == 2'd0) begin
                  o_re <= mem_re[rd_a];
                  o_im <= mem_im[rd_a];
                  step <= 2'd1;
               end else if (step == 2'd1) begin
                  if (out_ready) begin
                     ptr <= ptr + 1'b1;
                     if (ptr == AW'(N - 1)) begin
                        phase <= PH_LOAD;
                        step  <= 2'd0;
                        done  <= 1'b1;
                     end else begin
                        step <= 2'd2;
                     end
                  end
               end else begin
                  step <= 2'd0;
               end
            end
            default: phase <= PH_LOAD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         cnt_run <= 1'b0;
      end else if (in_ready && in_valid && ptr == AW'(N - 1)) begin
         cnt     <= '0;
         cnt_run <= 1'b1;
      end else if (cnt_run) begin
         cnt <= cnt + 1'b1;
         if (phase == PH_DRAIN) cnt_run <= 1'b0;
      end
   end

   logic [CW-1:0] fly_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || phase == PH_LOAD) fly_cnt <= '0;
      else if (adv) fly_cnt <= fly_cnt + 1'b1;
   end

   AST_FLY_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DRAIN && $past(phase) == PH_CALC) |-> fly_cnt == CW'(FLIES)); // R3
   AST_FIRST_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ptr == '0) |-> lat_cycles == CW'(LAT)); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_READY_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !cnt_run); // R1
endmodule

// File: tb/fft_stream_core_test.sv
module fft_stream_core_test;
   localparam int NP   = 64;
   localparam int LG   = 6;
   localparam int LAT  = 3 * (NP / 2) * LG + 3;
   localparam real TOL = 2.0 * LG * LG;
   localparam real TWO_PI = 6.283185307179586;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        done;
   logic [31:0] lat_cycles;

   fft_stream_core #(.N(NP), .DW(16), .FAC_SHIFT(14), .CW(32)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done(done), .lat_cycles(lat_cycles)
   );

   always #10 clk = ~clk;

   int nvec = 0;
   int nbad = 0;
   int cyc  = 0;
   int last_acc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic signed [15:0] xr [NP];
   logic signed [15:0] xi [NP];
   logic signed [15:0] yr [NP];
   logic signed [15:0] yi [NP];
   real er [NP];
   real ei [NP];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ref_dft();
      for (int k = 0; k < NP; k++) begin
         real sr = 0.0;
         real si = 0.0;
         for (int n = 0; n < NP; n++) begin
            real a = -TWO_PI * ((n * k) % NP) / NP;
            sr += xr[n] * $cos(a) - xi[n] * $sin(a);
            si += xr[n] * $sin(a) + xi[n] * $cos(a);
         end
         er[k] = sr;
         ei[k] = si;
      end
   endtask

   task automatic cmp_ref(input int from);
      for (int k = from; k < NP; k++) begin
         real dr = yr[k] - er[k];
         real di = yi[k] - ei[k];
         chk((dr <= TOL) && (dr >= -TOL), "R2 real", int'(yr[k]), $rtoi(er[k]));
         chk((di <= TOL) && (di >= -TOL), "R2 imag", int'(yi[k]), $rtoi(ei[k]));
      end
   endtask

   task automatic send_frame();
      int prev = -1;
      for (int n = 0; n < NP; n++) begin
         in_data  = {xi[n], xr[n]};
         in_valid = 1'b1;
         while (!in_ready) @(negedge clk);
         if (prev >= 0 && n < 4) chk(cyc - prev == 3, "R4 input spacing", cyc - prev, 3);
         prev     = cyc;
         last_acc = cyc;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic recv_frame(input bit bp);
      int k = 0;
      int prev = -1;
      bit pend = 1'b0;
      bit rdy_seen = 1'b0;
      logic [31:0] pd = '0;
      while (!out_valid) begin
         if (in_ready) rdy_seen = 1'b1;
         @(negedge clk);
      end
      chk(!rdy_seen, "R1 in_ready during compute", int'(rdy_seen), 0);
      chk(cyc - last_acc - 1 == LAT, "R3 compute edges", cyc - last_acc - 1, LAT);
      chk(lat_cycles == LAT, "R5 lat_cycles", int'(lat_cycles), LAT);
      while (k < NP) begin
         if (pend) chk(out_valid && out_data == pd, "R6 hold", int'(out_data), int'(pd));
         out_ready = bp ? 1'($urandom_range(1)) : 1'b1;
         if (out_valid && out_ready) begin
            yr[k] = out_data[15:0];
            yi[k] = out_data[31:16];
            if (!bp && prev >= 0 && k < 4) chk(cyc - prev == 3, "R4 output spacing", cyc - prev, 3);
            prev = cyc;
            k++;
            pend = 1'b0;
         end else begin
            pend = out_valid;
            pd   = out_data;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(done && in_ready, "R7 done with ready", int'({done, in_ready}), 3);
      @(negedge clk);
      chk(!done, "R7 done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      chk(in_ready && !out_valid && !done && lat_cycles == 0, "R9 in reset",
          int'({in_ready, out_valid, done}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !out_valid && !done && lat_cycles == 0, "R9 after reset",
          int'({in_ready, out_valid, done}), 4);

      // R8: impulse gives a flat spectrum, exactly
      for (int n = 0; n < NP; n++) begin xr[n] = '0; xi[n] = '0; end
      xr[0] = 16'sd1234;
      xi[0] = -16'sd567;
      send_frame();
      recv_frame(1'b0);
      for (int k = 0; k < NP; k++) begin
         chk(yr[k] == 16'sd1234, "R8 impulse real", int'(yr[k]), 1234);
         chk(yi[k] == -16'sd567, "R8 impulse imag", int'(yi[k]), -567);
      end

      // R10: DC sum of 64000 wraps to -1536
      for (int n = 0; n < NP; n++) begin xr[n] = 16'sd1000; xi[n] = '0; end
      ref_dft();
      send_frame();
      recv_frame(1'b0);
      chk(yr[0] == -16'sd1536, "R10 wrap real", int'(yr[0]), -1536);
      chk(yi[0] == 16'sd0, "R10 wrap imag", int'(yi[0]), 0);
      cmp_ref(1);

      // R2: random frames, one with output back-pressure (R6)
      for (int f = 0; f < 3; f++) begin
         for (int n = 0; n < NP; n++) begin
            xr[n] = 16'($signed($urandom_range(800)) - 400);
            xi[n] = 16'($signed($urandom_range(800)) - 400);
         end
         if (f == 2) begin
            xr[NP-1] = 16'sd400;
            xi[NP-1] = -16'sd400;
         end
         ref_dft();
         send_frame();
         recv_frame(f == 1);
         cmp_ref(0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule